// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a hardware watchdog whose 8-bit down-counter is loaded by software and then steps down once every 2^PRESCALE_LOG2 system clocks. With the default of 17 that is one step every 131072 cycles, about 763 Hz from a 100 MHz clock. Software keeps the system alive by restarting the counter before it runs out. If the counter is allowed to run down, the block first raises a one-cycle non-maskable interrupt request as the counter steps to 1. It then raises a chip reset request as the counter steps to 0. The reset request holds until the block's own reset input clears it.

All control goes through a single write port that carries a count, a command bit and a 7-bit key. Each write must carry the bitwise inverse of the key from the last accepted write, so a runaway program that keeps writing one fixed value cannot keep the watchdog alive or stop it. A write whose key is wrong changes nothing. After reset the block is stopped and holds no key. The first start write is taken with any key, and that key becomes the reference for the next write.

Top module: `guard_timer`

## Requirements
- R1: After reset both request outputs are low and the counter is stopped, so no request appears until a start write is accepted.
- R2: While no key is held, the first start write (`wrCmd`=1) is accepted whatever its key, and that key becomes the reference. A stop write (`wrCmd`=0) made before this is ignored and stores no key.
- R3: Once a reference is held, a write is accepted only when `wrKey` equals the reference XOR 7'h7F. An accepted key becomes the new reference, whether the write was a start or a stop.
- R4: A write with a wrong key is ignored completely: the count, the running state and the reference key all stay as they were.
- R5: An accepted start loads `wrCount` (the full 8 bits, 0 to 255) and runs the counter. A start made while the counter runs is a restart that reloads it.
- R6: The counter decrements once every 2^PRESCALE_LOG2 cycles. The prescaler restarts from zero on every accepted start, so the first decrement lands exactly one period after the clock edge that accepted the write.
- R7: `nmiReq` is high for exactly one cycle, the cycle after the edge where the counter steps from 2 to 1. A start loaded with 1 or 0 gives no NMI.
- R8: `chipRstReq` rises on the cycle after the edge where a step would take the counter to or below 0. A start loaded with N≥1 therefore raises it N periods after the write, and a start loaded with 0 raises it one period after. It then stays high until `rstN` is asserted.
- R9: An accepted stop halts counting, and no request is raised while the counter is stopped.
- R10: While `chipRstReq` is high, every write is ignored and the counter is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Control write strobe, one cycle per write |
| wrCount | input | 8 | Count value loaded by a start |
| wrCmd | input | 1 | 1 = start or restart, 0 = stop |
| wrKey | input | 7 | Key that must invert the previously accepted key |
| nmiReq | output | 1 | One-cycle NMI request when the counter steps to 1 |
| chipRstReq | output | 1 | Sticky reset request once the counter has expired |

## Verification
The assertions check the per-cycle invariants on every cycle. The NMI is a one-cycle pulse and it coincides with a count of 1. The reset request stays high and freezes the counter. A stopped counter holds its value, a running counter moves by at most one per step, and a rejected key leaves the stored reference untouched. What a property cannot show is the full key sequence and the exact timing, so the bench scenarios cover those. They check the exact cycle of each request after a write, restarts that reload the counter and realign the prescaler, and wrong-key and premature-stop writes that must change nothing. They also check that a stop changes the reference key and that writes made after expiry are ignored.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;

  typedef enum logic {
    CMD_STOP  = 1'b0,
    CMD_START = 1'b1
  } wd_cmd_e;

  // Strobes from the key/command control to the counting datapath
  typedef struct packed {
    logic load;   // accepted start: reload count, restart prescaler, run
    logic halt;   // accepted stop: halt counting
  } wd_strobe_t;

endpackage

// File: rtl/guard_timer_ctrl.sv
module guard_timer_ctrl
  import guard_timer_pkg::*;
#(
  parameter int KEY_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrCmd,
  input  logic [KEY_W-1:0] wrKey,
  input  logic             expired,
  output wd_strobe_t       strb
);

  localparam logic [KEY_W-1:0] KEY_FLIP = {KEY_W{1'b1}};

  logic [KEY_W-1:0] refKey;
  logic             keyValid;
  logic             keyMatch;
  logic             okWrite;
  wd_cmd_e          cmd;

  assign cmd      = wd_cmd_e'(wrCmd);
  assign keyMatch = (wrKey == (refKey ^ KEY_FLIP));

  always_comb begin
    okWrite = 1'b0;
    if (wrEn && !expired) begin
      if (keyValid) okWrite = keyMatch;
      else          okWrite = (cmd == CMD_START);
    end
    strb.load = okWrite && (cmd == CMD_START);
    strb.halt = okWrite && (cmd == CMD_STOP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refKey   <= '0;
      keyValid <= 1'b0;
    end else if (okWrite) begin
      refKey   <= wrKey;
      keyValid <= 1'b1;
    end
  end

  // R4: a write carrying a wrong key leaves the reference key in place
  assert_badkey_keeps_ref_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && keyValid && (wrKey != (refKey ^ KEY_FLIP))) |=> ($stable(refKey) && keyValid));

  // R2: the first reference key can only come from a start write
  assert_first_is_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!keyValid && wrEn && (cmd == CMD_STOP)) |=> !keyValid);

  // R10: after expiry the stored key no longer changes
  assert_expired_key_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    expired |=> $stable(refKey));

endmodule

// File: rtl/guard_timer_dp.sv
module guard_timer_dp
  import guard_timer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  wd_strobe_t       strb,
  input  logic [CNT_W-1:0] loadVal,
  output logic             nmiReq,
  output logic             chipRstReq
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_TWO = CNT_W'(2);

  logic [PRE_W-1:0] preQ;
  logic [CNT_W-1:0] cntQ;
  logic             running;
  logic             tick;

  assign tick = running && (preQ == {PRE_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preQ       <= '0;
      cntQ       <= '0;
      running    <= 1'b0;
      nmiReq     <= 1'b0;
      chipRstReq <= 1'b0;
    end else begin
      nmiReq <= 1'b0;
      if (chipRstReq) begin
        running <= 1'b0;
      end else if (strb.load) begin
        cntQ    <= loadVal;
        preQ    <= '0;
        running <= 1'b1;
      end else if (strb.halt) begin
        preQ    <= '0;
        running <= 1'b0;
      end else if (running) begin
        preQ <= preQ + 1'b1;
        if (tick) begin
          if (cntQ <= CNT_ONE) begin
            cntQ       <= '0;
            running    <= 1'b0;
            chipRstReq <= 1'b1;
          end else begin
            cntQ <= cntQ - 1'b1;
            if (cntQ == CNT_TWO) nmiReq <= 1'b1;
          end
        end
      end
    end
  end

  // R7: the NMI request is a single-cycle pulse
  assert_nmi_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |=> !nmiReq);

  // R7: the NMI request coincides with the counter sitting at one
  assert_nmi_at_one_R7: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |-> (cntQ == CNT_ONE));

  // R8: the reset request holds until the block is reset
  assert_rst_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    chipRstReq |=> chipRstReq);

  // R10: once expired the counter is frozen and stopped
  assert_rst_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    chipRstReq |=> ($stable(cntQ) && !running));

  // R9: a stopped counter holds its value unless a start arrives
  assert_halt_freezes_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !strb.load) |=> $stable(cntQ));

  // R6: a running counter moves by at most one step per cycle
  assert_single_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (running && !strb.load && !chipRstReq && (cntQ > CNT_ONE)) |=>
      ((cntQ == $past(cntQ)) || (cntQ == ($past(cntQ) - CNT_ONE))));

endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_timer_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int KEY_W         = 7,
  parameter int PRESCALE_LOG2 = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CNT_W-1:0] wrCount,
  input  logic             wrCmd,
  input  logic [KEY_W-1:0] wrKey,
  output logic             nmiReq,
  output logic             chipRstReq
);

  localparam int PRE_W = (PRESCALE_LOG2 < 1) ? 1 : PRESCALE_LOG2;

  wd_strobe_t strb;

  guard_timer_ctrl #(
    .KEY_W (KEY_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrCmd   (wrCmd),
    .wrKey   (wrKey),
    .expired (chipRstReq),
    .strb    (strb)
  );

  guard_timer_dp #(
    .CNT_W (CNT_W),
    .PRE_W (PRE_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .loadVal    (wrCount),
    .nmiReq     (nmiReq),
    .chipRstReq (chipRstReq)
  );

endmodule

// File: tb/tb_guard_timer.sv
module tb_guard_timer;

  localparam int CLK_PERIOD = 10;
  localparam int PRE_LOG2   = 3;
  localparam int PERIOD     = 1 << PRE_LOG2;
  localparam int EV_NMI     = 1;
  localparam int EV_RST     = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrCount = '0;
  logic       wrCmd = 1'b0;
  logic [6:0] wrKey = '0;
  logic       nmiReq;
  logic       chipRstReq;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  logic prevRst = 1'b0;

  typedef struct {
    int    kind;
    int    at;
    string req;
  } exp_t;
  exp_t expQ[$];

  guard_timer #(
    .CNT_W (8),
    .KEY_W (7),
    .PRESCALE_LOG2 (PRE_LOG2)
  ) dut (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrCount    (wrCount),
    .wrCmd      (wrCmd),
    .wrKey      (wrKey),
    .nmiReq     (nmiReq),
    .chipRstReq (chipRstReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // Monitor: pops expected events and compares kind and cycle
  always @(negedge clk) begin
    if (!rstN) begin
      prevRst <= 1'b0;
    end else begin
      int kind;
      kind = 0;
      if (nmiReq) kind = EV_NMI;
      else if (chipRstReq && !prevRst) kind = EV_RST;
      prevRst <= chipRstReq;
      if (kind != 0) begin
        if (expQ.size() == 0) begin
          check(1'b0, "unexpected request (R1/R4/R9/R10)", kind, 0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(e.kind == kind, e.req, kind, e.kind);
          check(e.at == cyc, e.req, cyc, e.at);
        end
      end
    end
  end

  // Driver: push the expected requests of a run loaded with n
  task automatic expectRun(input int e0, input int n, input string req);
    exp_t e;
    if (n >= 2) begin
      e.kind = EV_NMI; e.at = e0 + PERIOD*(n-1); e.req = req;
      expQ.push_back(e);
    end
    e.kind = EV_RST; e.at = e0 + PERIOD*((n < 1) ? 1 : n); e.req = req;
    expQ.push_back(e);
  endtask

  task automatic wrWrite(input bit cmd, input int cnt, input int key, output int edgeCyc);
    @(negedge clk);
    wrEn = 1'b1; wrCmd = cmd; wrCount = 8'(cnt); wrKey = 7'(key);
    @(posedge clk);
    #1 edgeCyc = cyc;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic drain(input int n, input string req);
    repeat (n) @(negedge clk);
    check(expQ.size() == 0, req, expQ.size(), 0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0;
    expQ.delete();
    repeat (3) @(negedge clk);
    check(nmiReq == 1'b0, "R1 nmi low in reset", nmiReq, 0);
    check(chipRstReq == 1'b0, "R1 reset request low in reset", chipRstReq, 0);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int e0;
    int e1;

    // R1: idle after reset
    doReset();
    drain(200, "R1 no request without start");
    check(chipRstReq == 1'b0, "R1 idle output", chipRstReq, 0);

    // R5/R7/R8: plain run, then sticky reset and R10 ignored writes
    wrWrite(1'b1, 4, 7'h2A, e0);
    expectRun(e0, 4, "R7/R8 run of 4");
    drain(40, "R7 R8 run completes");
    repeat (20) @(negedge clk);
    check(chipRstReq == 1'b1, "R8 reset request sticky", chipRstReq, 1);
    wrWrite(1'b1, 3, 7'h55, e1);
    drain(40, "R10 write after expiry ignored");
    check(chipRstReq == 1'b1, "R10 reset request held", chipRstReq, 1);

    // R6: restart off the prescaler boundary realigns it
    doReset();
    wrWrite(1'b1, 5, 7'h15, e0);
    repeat (10) @(negedge clk);
    wrWrite(1'b1, 5, 7'h6A, e1);
    expectRun(e1, 5, "R5/R6 restart reload");
    drain(60, "R6 restart timing");

    // R4: wrong-key start and stop change nothing
    doReset();
    wrWrite(1'b1, 6, 7'h10, e0);
    expectRun(e0, 6, "R4 original run kept");
    wrWrite(1'b1, 2, 7'h10, e1);
    wrWrite(1'b0, 0, 7'h11, e1);
    drain(70, "R4 wrong keys ignored");

    // R9/R3: valid stop, stale key rejected, inverse accepted
    doReset();
    wrWrite(1'b1, 3, 7'h01, e0);
    wrWrite(1'b0, 0, 7'h7E, e1);
    drain(60, "R9 stop halts");
    wrWrite(1'b1, 2, 7'h7E, e1);
    drain(40, "R3 non-inverted key rejected");
    wrWrite(1'b1, 3, 7'h01, e1);
    expectRun(e1, 3, "R3 inverted key accepted");
    drain(40, "R3 run after stop");

    // R2: stop before any key is ignored, first start takes any key
    doReset();
    wrWrite(1'b0, 0, 7'h40, e0);
    wrWrite(1'b1, 3, 7'h33, e1);
    expectRun(e1, 3, "R2 first start any key");
    drain(40, "R2 first start");

    // R7/R8: loads of 1 and 0 give no NMI
    doReset();
    wrWrite(1'b1, 1, 7'h05, e0);
    expectRun(e0, 1, "R7 load one no nmi");
    drain(20, "R7 load one");
    doReset();
    wrWrite(1'b1, 0, 7'h05, e0);
    expectRun(e0, 0, "R8 load zero");
    drain(20, "R8 load zero");

    // R5: full-width count
    doReset();
    wrWrite(1'b1, 255, 7'h3C, e0);
    expectRun(e0, 255, "R5 full count 255");
    drain(PERIOD*255 + 20, "R5 full count");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule